// File: doc/BRIEF.md
# Shared-Line Source Selector with Dead Time

This block arbitrates ownership of one shared data line among eight sources. A 3-bit code names the wanted source, and a master enable allows any driving at all. The block turns the code into one-hot driver enables. At most one source can place its data on the line, and the line is released to high impedance when nobody owns it.

Switching ownership never passes the line straight from one driver to the next. When the wanted owner changes, every enable drops first. The line then stays undriven for a fixed number of clock cycles before the new owner is enabled. This gap absorbs the spread between driver turn-off and turn-on times and the skew on the enable wires. A busy flag marks the gap, so upstream logic knows that a handover is in progress.

Top module: `shared_line_sel`

## Requirements
- R1: While a driver enable is set, `line_o` equals the data of that source, taken from `src_data_i[k*DATA_W +: DATA_W]` for source k, and follows changes of that data within the same cycle. While no enable is set, `line_o` is released (high impedance).
- R2: `drv_en_o` bit k is the enable of source k, and at most one bit of `drv_en_o` is high in any cycle.
- R3: When `en_i` is sampled low at a clock edge, `drv_en_o` is all zero after that edge. Any pending handover is discarded.
- R4: When the sampled code differs from the current owner or target, or when `en_i` rises while the block is idle, all enables are zero for exactly DEAD_CYCLES cycles (default 2). After that the enable of the new source is set. Two different enables are never set in consecutive cycles.
- R5: A code change during the dead interval restarts the full count, and the source enabled afterwards is the latest code.
- R6: `busy_o` is high exactly during the dead interval: from the edge that detects the change up to the edge that sets the new enable. While `busy_o` is high, `drv_en_o` is zero.
- R7: While `rst_ni` is low (asynchronous, active low), `drv_en_o` is zero and `busy_o` is low, with no clock edge needed. After release the block is idle.
- R8: While the code is held steady and `en_i` stays high, the owner stays enabled in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable; low releases every driver |
| sel_i | input | SEL_W (3) | Code of the wanted source |
| src_data_i | input | NSRC*DATA_W | Packed data of all sources, source k at bits k*DATA_W upward |
| drv_en_o | output | NSRC | One-hot driver enables |
| busy_o | output | 1 | Dead interval in progress |
| line_o | output | DATA_W | Shared line, Hi-Z when no owner |

## Verification
A wrong state or target register shows up at `drv_en_o` on the first edge after the event that should have moved it. Examples are a bit for the old source, a bit for a stale code, or two bits at once. A dead-time counter that loads or expires wrongly moves the rising enable earlier or later than DEAD_CYCLES edges after the change, and `busy_o` moves with it. A fault in the data path shows in the same cycle as a `line_o` value that differs from the owner's data.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEAD  = 2'd1,
    ST_DRIVE = 2'd2
  } sls_state_e;
endpackage

// File: rtl/sls_dead_timer.sv
module sls_dead_timer #(
  parameter int unsigned DEAD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(DEAD_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= CW'(DEAD_CYCLES);
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sls_onehot_dec.sv
module sls_onehot_dec #(
  parameter int unsigned NSRC = 8,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] code_i,
  output logic [NSRC-1:0]  hot_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    assign hot_o[k] = en_i && (code_i == SEL_W'(k));
  end
endmodule

// File: rtl/sls_line_mux.sv
module sls_line_mux #(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned DATA_W = 4
) (
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]      val_o
);
  // AND-OR mux; relies on one-hot enables
  always_comb begin
    val_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (en_i[k]) val_o = val_o | data_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/shared_line_sel.sv
module shared_line_sel
  import sls_pkg::*;
#(
  parameter int unsigned NSRC        = 8,
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned DEAD_CYCLES = 2,
  localparam int unsigned SEL_W      = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [NSRC*DATA_W-1:0] src_data_i,
  output logic [NSRC-1:0]        drv_en_o,
  output logic                   busy_o,
  output logic [DATA_W-1:0]      line_o
);
  sls_state_e       st_q, st_d;
  logic [SEL_W-1:0] tgt_q, tgt_d;
  logic             load, dec, last;
  logic [DATA_W-1:0] mux_val;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    load  = 1'b0;
    dec   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          st_d  = ST_DEAD;
          tgt_d = sel_i;
          load  = 1'b1;
        end
      end
      ST_DEAD: begin
        if (!en_i) begin
          st_d = ST_IDLE;
        end else if (sel_i != tgt_q) begin
          tgt_d = sel_i;  // restart toward latest code
          load  = 1'b1;
        end else if (last) begin
          st_d = ST_DRIVE;
        end else begin
          dec = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (!en_i) begin
          st_d = ST_IDLE;
        end else if (sel_i != tgt_q) begin
          st_d  = ST_DEAD;
          tgt_d = sel_i;
          load  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  sls_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (dec),
    .last_o (last)
  );

  sls_onehot_dec #(.NSRC(NSRC)) u_dec (
    .en_i   (st_q == ST_DRIVE),
    .code_i (tgt_q),
    .hot_o  (drv_en_o)
  );

  sls_line_mux #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mux (
    .en_i   (drv_en_o),
    .data_i (src_data_i),
    .val_o  (mux_val)
  );

  assign busy_o = (st_q == ST_DEAD);
  assign line_o = (|drv_en_o) ? mux_val : {DATA_W{1'bz}};
endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int unsigned NSRC        = 8,
  parameter int unsigned DEAD_CYCLES = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [NSRC-1:0] drv_en_o,
  input logic            busy_o
);
  localparam int unsigned GW = $clog2(DEAD_CYCLES + 1) + 1;

  logic [GW-1:0] gap_q;  // consecutive sampled cycles with no owner

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gap_q <= '0;
    else if (|drv_en_o)                 gap_q <= '0;
    else if (gap_q < GW'(DEAD_CYCLES))  gap_q <= gap_q + 1'b1;
  end

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_en_o));

  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (drv_en_o == '0));

  a_r4_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|drv_en_o) && !$past(|drv_en_o)) |-> (gap_q >= GW'(DEAD_CYCLES)));

  a_r4_no_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|drv_en_o) && (|$past(drv_en_o))) |-> (drv_en_o == $past(drv_en_o)));

  a_r6_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (drv_en_o == '0));
endmodule

bind shared_line_sel sls_checker #(
  .NSRC(NSRC),
  .DEAD_CYCLES(DEAD_CYCLES)
) u_sls_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .drv_en_o (drv_en_o),
  .busy_o   (busy_o)
);

// File: tb/tb_shared_line_sel.sv
module tb_shared_line_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int DW   = 4;
  localparam int DEAD = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en = 1'b0;
  logic [2:0]        sel = '0;
  logic [NSRC*DW-1:0] src = '0;
  logic [NSRC-1:0]   drv_en;
  logic              busy;
  wire  [DW-1:0]     line;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_line_sel #(.NSRC(NSRC), .DATA_W(DW), .DEAD_CYCLES(DEAD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sel_i(sel),
    .src_data_i(src), .drv_en_o(drv_en), .busy_o(busy), .line_o(line)
  );

  // {en, sel, expected drv_en, expected busy}; state after one edge, DEAD=2
  localparam logic [12:0] VEC [20] = '{
    {1'b0, 3'd0, 8'h00, 1'b0},  // idle
    {1'b1, 3'd3, 8'h00, 1'b1},  // R4 start from idle
    {1'b1, 3'd3, 8'h00, 1'b1},
    {1'b1, 3'd3, 8'h08, 1'b0},  // R4 owner 3 after DEAD cycles
    {1'b1, 3'd3, 8'h08, 1'b0},  // R8 hold
    {1'b1, 3'd5, 8'h00, 1'b1},  // R4 change
    {1'b1, 3'd5, 8'h00, 1'b1},
    {1'b1, 3'd6, 8'h00, 1'b1},  // R5 restart
    {1'b1, 3'd6, 8'h00, 1'b1},
    {1'b1, 3'd6, 8'h40, 1'b0},  // R5 latest code wins
    {1'b0, 3'd6, 8'h00, 1'b0},  // R3 release
    {1'b1, 3'd7, 8'h00, 1'b1},
    {1'b1, 3'd7, 8'h00, 1'b1},
    {1'b1, 3'd7, 8'h80, 1'b0},
    {1'b1, 3'd0, 8'h00, 1'b1},
    {1'b0, 3'd0, 8'h00, 1'b0},  // R3 abort handover
    {1'b1, 3'd0, 8'h00, 1'b1},
    {1'b1, 3'd0, 8'h00, 1'b1},
    {1'b1, 3'd0, 8'h01, 1'b0},
    {1'b1, 3'd0, 8'h01, 1'b0}   // R8 hold
  };

  function automatic logic [DW-1:0] pat(int k);
    return DW'(k * 3 + 1);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_line(logic [NSRC-1:0] exp_en, string req);
    for (int k = 0; k < NSRC; k++) begin
      if (exp_en[k]) begin
        logic [DW-1:0] e;
        e = src[k*DW +: DW];
        check(line === e, req, 32'(line), 32'(e));
      end
    end
  endtask

  task automatic step_check(logic e, logic [2:0] s, logic [7:0] xe, logic xb, string req);
    en = e; sel = s;
    @(posedge clk); @(negedge clk);
    check(drv_en === xe, req, 32'(drv_en), 32'(xe));
    check(busy === xb, {req, " busy"}, 32'(busy), 32'(xb));
    if (xe != 0) check_line(xe, {req, " R1 line"});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < NSRC; k++) src[k*DW +: DW] = pat(k);
    @(negedge clk);
    // R7 reset state
    check(drv_en === 8'h00, "R7 reset enables", 32'(drv_en), 32'h0);
    check(busy === 1'b0, "R7 reset busy", 32'(busy), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 20; i++) begin
      step_check(VEC[i][12], VEC[i][11:9], VEC[i][8:1], VEC[i][0], "R2 R4 R5 R6 table");
    end

    // R1 line follows owner data in same cycle
    src[0 +: DW] = 4'hA;
    #1;
    check(line === 4'hA, "R1 data follow", 32'(line), 32'hA);

    // R7 asynchronous reset while driving
    #1 rst_ni = 1'b0;
    #1;
    check(drv_en === 8'h00, "R7 async enables", 32'(drv_en), 32'h0);
    check(busy === 1'b0, "R7 async busy", 32'(busy), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R4 after reset: dead time before first owner
    step_check(1'b1, 3'd2, 8'h00, 1'b1, "R4 post-reset");
    step_check(1'b1, 3'd2, 8'h00, 1'b1, "R4 post-reset");
    step_check(1'b1, 3'd2, 8'h04, 1'b0, "R4 post-reset owner");
    // R5 glitch back to same code during dead time still restarts count
    step_check(1'b1, 3'd4, 8'h00, 1'b1, "R5 change");
    step_check(1'b1, 3'd2, 8'h00, 1'b1, "R5 back");
    step_check(1'b1, 3'd2, 8'h00, 1'b1, "R5 restart");
    step_check(1'b1, 3'd2, 8'h04, 1'b0, "R5 owner 2");
    // R3 en low while dead
    step_check(1'b1, 3'd1, 8'h00, 1'b1, "R3 setup");
    step_check(1'b0, 3'd1, 8'h00, 1'b0, "R3 cancel");
    step_check(1'b0, 3'd1, 8'h00, 1'b0, "R3 stay idle");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule